// File: doc/BRIEF.md
# Software Command Address-Sequence Detector

This block watches the accesses made to an asynchronous SRAM-style interface and looks for a fixed unlock sequence of six reads. When it finds one, it issues a nonvolatile command. Every access reaches the block as a one-cycle strobe `acc_valid`, sampled on a rising clock edge, together with `acc_write` and the address. The access interface forms that strobe at the edge that ends the access, whether chip enable or output enable ends the read. Whether output enable was low does not matter to the detector. Five fixed unlock reads must come in order. The sixth read then chooses one of three commands: a copy of the array into nonvolatile storage, a restore from nonvolatile storage, or a disable of the automatic power-fail copy.

After the sixth read the detector waits for a quiet window of `QUIET_CYC` clock cycles. If any access arrives in that window, the command is discarded. If the window passes with no access, the block emits a one-cycle command pulse and holds `busy` high. While `busy` is high, further accesses are blocked from the sequence logic. `busy` clears when the operation engine returns `op_done`.

The states are `ST_IDLE`, `ST_GOT1` to `ST_GOT5` (count of unlock reads matched), `ST_WAIT` (quiet window) and `ST_BUSY`. The transitions are as follows:
- A read that matches the expected step advances the state (from `ST_GOT5` to `ST_WAIT` on a command address).
- A write returns the state to `ST_IDLE`.
- A non-matching read goes to `ST_GOT1` if it is the first unlock address, and to `ST_IDLE` otherwise.
- In `ST_WAIT`, any access goes to `ST_IDLE`. Expiry of the window goes to `ST_BUSY` and emits the pulse.
- `ST_BUSY` goes to `ST_IDLE` on `op_done`.

Top module: `swcmd_detect`

## Requirements
- R1: After reset, `cmd_store`, `cmd_recall`, `cmd_nostore` and `busy` are all low.
- R2: Reads of 0x4E38, 0xB1C7, 0x83E0, 0x7C1F, 0x703F, then 0x8FC0, followed by `QUIET_CYC` access-free clock edges, raise `cmd_store` for exactly one cycle. The pulse appears in the cycle after the `QUIET_CYC`-th edge that follows the sixth read's edge.
- R3: With 0x4C63 as the sixth address, the pulse is on `cmd_recall`. With 0x8B45, it is on `cmd_nostore`. At most one command output is high in any cycle.
- R4: Only address bits 14 down to 2 are compared. Bits 1:0 and bits 15 and above may take any value without changing the outcome.
- R5: A write (`acc_write`=1) in place of any of the six reads, or between them, aborts the sequence, and no command is issued.
- R6: A read whose address does not match the expected step aborts the sequence. If that read matches 0x4E38, it counts as step one of a new sequence.
- R7: Any access on one of the `QUIET_CYC` edges after the sixth read, including the last one, discards the command. The detector returns to idle and no pulse follows.
- R8: `busy` rises together with the command pulse and stays high until `op_done` is sampled. It is low in the cycle after that edge. Accesses made while `busy` is high have no effect on the sequence.
- R9: A sixth read whose address is none of the three command addresses (and not 0x4E38) ends the sequence with no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for access strobes and quiet-window timing |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | One-cycle strobe marking a completed access |
| acc_write | input | 1 | 1 when the strobed access is a write |
| acc_addr | input | ADDR_W | Address of the strobed access |
| op_done | input | 1 | Pulse from the operation engine ending the busy period |
| cmd_store | output | 1 | One-cycle pulse: copy array into nonvolatile storage |
| cmd_recall | output | 1 | One-cycle pulse: restore array from nonvolatile storage |
| cmd_nostore | output | 1 | One-cycle pulse: disable automatic power-fail copy |
| busy | output | 1 | High from command issue until `op_done` |

## Verification
Three kinds of sequence are applied:
- Clean sequences for each of the three command addresses, with random noise on the don't-care address bits and random gaps between the unlock reads. These separate correct key matching and command decoding from a design that compares the wrong bits or reacts to gaps.
- Sequences disturbed at a random step by a write or a foreign read, and sequences with a stray access at a random edge inside the quiet window. These show whether each abort path really drops the command, and whether the window has exactly the right length.
- Directed cases: a restart on a repeated first address, an access on the final quiet edge, a non-command sixth address, and a full sequence sent while busy. These cover the boundaries that random runs seldom reach.

// File: rtl/swcmd_pkg.sv
package swcmd_pkg;

    localparam int KEY_LO    = 2;
    localparam int KEY_HI    = 14;
    localparam int KEY_W     = KEY_HI - KEY_LO + 1;
    localparam int UNLOCK_N  = 5;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_STORE,
        CMD_RECALL,
        CMD_NOSTORE
    } cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_GOT1,
        ST_GOT2,
        ST_GOT3,
        ST_GOT4,
        ST_GOT5,
        ST_WAIT,
        ST_BUSY
    } state_e;

    // Unlock addresses, in the order they must arrive.
    function automatic logic [15:0] unlock_addr(input int idx);
        case (idx)
            0:       return 16'h4E38;
            1:       return 16'hB1C7;
            2:       return 16'h83E0;
            3:       return 16'h7C1F;
            default: return 16'h703F;
        endcase
    endfunction

    function automatic logic [15:0] command_addr(input cmd_e c);
        case (c)
            CMD_STORE:   return 16'h8FC0;
            CMD_RECALL:  return 16'h4C63;
            CMD_NOSTORE: return 16'h8B45;
            default:     return 16'h0000;
        endcase
    endfunction

endpackage

// File: rtl/swcmd_match.sv
module swcmd_match
    import swcmd_pkg::*;
(
    input  logic [KEY_W-1:0]    key,
    output logic [UNLOCK_N-1:0] step_hit,
    output cmd_e                cmd_hit
);

    for (genvar g = 0; g < UNLOCK_N; g++) begin : g_step
        localparam logic [15:0] PAT = unlock_addr(g);
        assign step_hit[g] = (key == PAT[KEY_HI:KEY_LO]);
    end

    localparam logic [15:0] PAT_ST = command_addr(CMD_STORE);
    localparam logic [15:0] PAT_RC = command_addr(CMD_RECALL);
    localparam logic [15:0] PAT_NS = command_addr(CMD_NOSTORE);

    always_comb begin
        if (key == PAT_ST[KEY_HI:KEY_LO])
            cmd_hit = CMD_STORE;
        else if (key == PAT_RC[KEY_HI:KEY_LO])
            cmd_hit = CMD_RECALL;
        else if (key == PAT_NS[KEY_HI:KEY_LO])
            cmd_hit = CMD_NOSTORE;
        else
            cmd_hit = CMD_NONE;
    end

endmodule

// File: rtl/swcmd_quiet.sv
module swcmd_quiet #(
    parameter int QUIET_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic done
);

    localparam int CW = $clog2(QUIET_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(QUIET_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (!done)
            cnt <= cnt + 1'b1;
    end

    assign done = (cnt == LAST);

endmodule

// File: rtl/swcmd_fsm.sv
module swcmd_fsm
    import swcmd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_valid,
    input  logic                acc_write,
    input  logic [UNLOCK_N-1:0] step_hit,
    input  cmd_e                cmd_hit,
    input  logic                quiet_done,
    input  logic                op_done,
    output logic                timer_clr,
    output logic                cmd_store,
    output logic                cmd_recall,
    output logic                cmd_nostore,
    output logic                busy
);

    state_e state, nxt;
    cmd_e   cmd_q;
    logic   exp_hit;
    state_e adv;

    // Expected match and successor for each stepping state.
    always_comb begin
        exp_hit = 1'b0;
        adv     = ST_IDLE;
        unique case (state)
            ST_IDLE: begin exp_hit = step_hit[0]; adv = ST_GOT1; end
            ST_GOT1: begin exp_hit = step_hit[1]; adv = ST_GOT2; end
            ST_GOT2: begin exp_hit = step_hit[2]; adv = ST_GOT3; end
            ST_GOT3: begin exp_hit = step_hit[3]; adv = ST_GOT4; end
            ST_GOT4: begin exp_hit = step_hit[4]; adv = ST_GOT5; end
            ST_GOT5: begin exp_hit = (cmd_hit != CMD_NONE); adv = ST_WAIT; end
            ST_WAIT: begin exp_hit = 1'b0; adv = ST_IDLE; end
            ST_BUSY: begin exp_hit = 1'b0; adv = ST_IDLE; end
            default: begin exp_hit = 1'b0; adv = ST_IDLE; end
        endcase
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE, ST_GOT1, ST_GOT2, ST_GOT3, ST_GOT4, ST_GOT5: begin
                if (acc_valid) begin
                    if (acc_write)
                        nxt = ST_IDLE;
                    else if (exp_hit)
                        nxt = adv;
                    else if (step_hit[0])
                        nxt = ST_GOT1;
                    else
                        nxt = ST_IDLE;
                end
            end
            ST_WAIT: begin
                if (acc_valid)
                    nxt = ST_IDLE;
                else if (quiet_done)
                    nxt = ST_BUSY;
            end
            ST_BUSY: begin
                if (op_done)
                    nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign timer_clr = (state != ST_WAIT);

    // State register and command latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cmd_q <= CMD_NONE;
        end else begin
            state <= nxt;
            if (state == ST_GOT5 && nxt == ST_WAIT)
                cmd_q <= cmd_hit;
        end
    end

    // Registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_store   <= 1'b0;
            cmd_recall  <= 1'b0;
            cmd_nostore <= 1'b0;
            busy        <= 1'b0;
        end else begin
            cmd_store   <= (state == ST_WAIT) && (nxt == ST_BUSY) && (cmd_q == CMD_STORE);
            cmd_recall  <= (state == ST_WAIT) && (nxt == ST_BUSY) && (cmd_q == CMD_RECALL);
            cmd_nostore <= (state == ST_WAIT) && (nxt == ST_BUSY) && (cmd_q == CMD_NOSTORE);
            busy        <= (nxt == ST_BUSY);
        end
    end

endmodule

// File: rtl/swcmd_detect.sv
module swcmd_detect
    import swcmd_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int QUIET_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              op_done,
    output logic              cmd_store,
    output logic              cmd_recall,
    output logic              cmd_nostore,
    output logic              busy
);

    logic [UNLOCK_N-1:0] step_hit;
    cmd_e                cmd_hit;
    logic                timer_clr;
    logic                quiet_done;
    logic                unused_bits;

    assign unused_bits = ^{acc_addr[ADDR_W-1:KEY_HI+1], acc_addr[KEY_LO-1:0]};

    swcmd_match u_match (
        .key      (acc_addr[KEY_HI:KEY_LO]),
        .step_hit (step_hit),
        .cmd_hit  (cmd_hit)
    );

    swcmd_quiet #(.QUIET_CYC(QUIET_CYC)) u_quiet (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (timer_clr),
        .done  (quiet_done)
    );

    swcmd_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid   (acc_valid),
        .acc_write   (acc_write),
        .step_hit    (step_hit),
        .cmd_hit     (cmd_hit),
        .quiet_done  (quiet_done),
        .op_done     (op_done),
        .timer_clr   (timer_clr),
        .cmd_store   (cmd_store),
        .cmd_recall  (cmd_recall),
        .cmd_nostore (cmd_nostore),
        .busy        (busy)
    );

endmodule

// File: rtl/swcmd_sva.sv
module swcmd_sva #(
    parameter int QUIET_CYC = 16
) (
    input logic clk,
    input logic rst_n,
    input logic acc_valid,
    input logic acc_write,
    input logic op_done,
    input logic cmd_store,
    input logic cmd_recall,
    input logic cmd_nostore,
    input logic busy
);

    localparam int CW = $clog2(QUIET_CYC + 2);

    logic          cmd_any;
    logic [CW-1:0] idle_run;

    assign cmd_any = cmd_store | cmd_recall | cmd_nostore;

    always_ff @(posedge clk) begin
        if (!rst_n || acc_valid)
            idle_run <= '0;
        else if (idle_run != CW'(QUIET_CYC + 1))
            idle_run <= idle_run + 1'b1;
    end

    p_one_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_store, cmd_recall, cmd_nostore}));

    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_any |=> !cmd_any);

    p_quiet_before_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_any |-> (idle_run >= CW'(QUIET_CYC)));

    p_write_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write) |=> !cmd_any);

    p_busy_with_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_any |-> busy);

    p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !op_done) |=> busy);

    p_busy_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_done) |=> !busy);

    p_no_cmd_when_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !cmd_any);

endmodule

bind swcmd_detect swcmd_sva #(.QUIET_CYC(QUIET_CYC)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_write   (acc_write),
    .op_done     (op_done),
    .cmd_store   (cmd_store),
    .cmd_recall  (cmd_recall),
    .cmd_nostore (cmd_nostore),
    .busy        (busy)
);

// File: tb/swcmd_detect_bench.sv
`timescale 1ns/1ps
module swcmd_detect_bench;

    localparam int ADDR_W = 19;
    localparam int Q      = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              acc_valid = 1'b0;
    logic              acc_write = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic              op_done = 1'b0;
    logic              cmd_store, cmd_recall, cmd_nostore, busy;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    swcmd_detect #(.ADDR_W(ADDR_W), .QUIET_CYC(Q)) u_swcmd_detect (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .op_done(op_done), .cmd_store(cmd_store),
        .cmd_recall(cmd_recall), .cmd_nostore(cmd_nostore), .busy(busy)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got %0d cycles expected under 150000", cycles);
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    function automatic logic [15:0] key_a(input int step);
        case (step)
            1: return 16'h4E38;
            2: return 16'hB1C7;
            3: return 16'h83E0;
            4: return 16'h7C1F;
            default: return 16'h703F;
        endcase
    endfunction

    // Command code: 1 store, 2 recall, 3 disable power-fail copy, 0 none.
    function automatic logic [15:0] cmd_a(input int code);
        case (code)
            1: return 16'h8FC0;
            2: return 16'h4C63;
            3: return 16'h8B45;
            default: return 16'h0000;
        endcase
    endfunction

    // Expected command: only an undisturbed sequence produces one.
    function automatic int expect_cmd(input int disturb, input int code);
        return (disturb == 0) ? code : 0;
    endfunction

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive_now(input logic [15:0] a, input bit wr, input bit noise);
        logic [ADDR_W-1:0] full;
        full = {{(ADDR_W-16){1'b0}}, a};
        if (noise) begin
            full[ADDR_W-1:15] = $urandom;
            full[1:0]         = $urandom;
        end
        acc_valid = 1'b1;
        acc_write = wr;
        acc_addr  = full;
        @(negedge clk);
        acc_valid = 1'b0;
        acc_write = 1'b0;
    endtask

    task automatic feed(input logic [15:0] a, input bit wr, input bit noise);
        @(negedge clk);
        drive_now(a, wr, noise);
    endtask

    task automatic release_busy();
        @(negedge clk);
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
    endtask

    // Called at the negedge after the sixth read's edge.
    task automatic observe(input int exp, input string req);
        int n = 0;
        int at = 0;
        int code = 0;
        for (int i = 1; i <= Q + 3; i++) begin
            @(negedge clk);
            if (cmd_store | cmd_recall | cmd_nostore) begin
                n++;
                at = i;
                code = cmd_store ? 1 : (cmd_recall ? 2 : 3);
            end
        end
        check(req, n, (exp != 0) ? 1 : 0, "pulse count");
        if (exp != 0) begin
            check(req, at, Q, "pulse cycle");
            check(req, code, exp, "command code");
            check("R8", int'(busy), 1, "busy held");
            release_busy();
            check("R8", int'(busy), 0, "busy after op_done");
        end else begin
            check(req, int'(busy), 0, "busy");
        end
    endtask

    task automatic full_seq(input int code, input bit noise, input int gapmax);
        for (int s = 1; s <= 5; s++) begin
            repeat ($urandom_range(gapmax, 0)) @(negedge clk);
            feed(key_a(s), 1'b0, noise);
        end
        repeat ($urandom_range(gapmax, 0)) @(negedge clk);
        feed(cmd_a(code), 1'b0, noise);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        check("R1", int'({cmd_store, cmd_recall, cmd_nostore, busy}), 0, "outputs in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'({cmd_store, cmd_recall, cmd_nostore, busy}), 0, "outputs after reset");

        // R2 / R3 clean sequences, no noise.
        full_seq(1, 1'b0, 0); observe(1, "R2");
        full_seq(2, 1'b0, 0); observe(2, "R3");
        full_seq(3, 1'b0, 0); observe(3, "R3");

        // R4 noise on don't-care bits.
        full_seq(1, 1'b1, 2); observe(1, "R4");

        // R6 restart on repeated first address.
        feed(key_a(1), 1'b0, 1'b0);
        feed(key_a(2), 1'b0, 1'b0);
        feed(key_a(1), 1'b0, 1'b0);
        for (int s = 2; s <= 5; s++) feed(key_a(s), 1'b0, 1'b0);
        feed(cmd_a(2), 1'b0, 1'b0);
        observe(2, "R6");

        // R9 non-command sixth address.
        for (int s = 1; s <= 5; s++) feed(key_a(s), 1'b0, 1'b0);
        feed(16'h1234, 1'b0, 1'b0);
        observe(0, "R9");

        // R7 access on the last quiet edge.
        full_seq(1, 1'b0, 0);
        repeat (Q - 1) @(negedge clk);
        drive_now(16'h0000, 1'b0, 1'b0);
        observe(0, "R7");

        // R8 sequence while busy is ignored.
        full_seq(3, 1'b0, 0);
        repeat (Q) @(negedge clk);
        check("R8", int'(busy), 1, "busy after command");
        full_seq(1, 1'b0, 0);
        repeat (Q + 3) @(negedge clk);
        check("R8", int'(cmd_store | cmd_recall | cmd_nostore), 0, "no pulse while busy");
        check("R8", int'(busy), 1, "busy still held");
        release_busy();
        check("R8", int'(busy), 0, "released");
        full_seq(2, 1'b0, 0); observe(2, "R8");

        // Random trials.
        for (int t = 0; t < 60; t++) begin
            int code = $urandom_range(3, 1);
            int kind = $urandom_range(3, 0);
            int dstep = $urandom_range(6, 1);
            int dcyc = $urandom_range(Q, 1);
            string req;
            req = (kind == 0) ? "R4" : (kind == 1) ? "R5" : (kind == 2) ? "R6" : "R7";
            for (int s = 1; s <= 6; s++) begin
                logic [15:0] a;
                a = (s == 6) ? cmd_a(code) : key_a(s);
                repeat ($urandom_range(2, 0)) @(negedge clk);
                if (kind == 1 && s == dstep)
                    feed(a, 1'b1, 1'b1);
                else if (kind == 2 && s == dstep)
                    feed(16'h0000, 1'b0, 1'b1);
                else
                    feed(a, 1'b0, 1'b1);
            end
            if (kind == 3) begin
                repeat (dcyc - 1) @(negedge clk);
                drive_now(16'h0000, 1'b0, 1'b1);
            end
            observe(expect_cmd(kind, code), req);
        end

        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule